// File: doc/BRIEF.md
# Parallel Configuration Byte Loader

This block takes configuration bytes from a host processor over a parallel write port, turns each byte into a serial bit stream for the device's internal configuration shift path, and passes bits that the local device does not keep on to the next device in a daisy chain.

The write port uses three active-low select lines and one active-high write strobe. A write is requested only while all four are asserted together. The byte is taken when any one of the four is released. The host then watches the `ready` flag before it writes the next byte. The port is asynchronous to the block clock, so the combined write term passes through a synchronizer. The data bus passes through a matching delay line, which keeps the captured byte aligned with the detected release.

A captured byte leaves the block one bit per clock, most significant bit first, with a valid strobe on each bit. A per-cycle input, `localTake`, says whether the local configuration path keeps the current bit. When it does not, the bit appears on the chain output one clock later; otherwise the chain output rests high. A write that arrives while a byte is still streaming is dropped and latches an overrun flag.

Top module: `cfg_byte_loader`

## Requirements
- R1: While `rstN` is low and after it returns high: `ready`=1, `serValid`=0, `serBit`=0, `chainOut`=1, `overrun`=0.
- R2: A write is requested only while `selN`=3'b000 and `wrStrobe`=1 together. Asserting and releasing any smaller subset starts no stream and leaves `ready` high.
- R3: When the last rising clock edge on which all four strobes are asserted is followed by their release, `serValid` stays low after the next two rising edges and goes high after the third. The captured byte is the `dataIn` value present on that last asserted edge. Releasing any one of the four strobes works the same way.
- R4: `ready` goes low when the stream starts and returns high after exactly DATA_W (8) consecutive cycles of `serValid`.
- R5: Bits leave on `serBit` one per clock, most significant bit first. `serValid` is high on each of them.
- R6: A write whose release is detected while a byte is still streaming is ignored: the current stream goes on unchanged and no extra bits follow. The ignored write sets `overrun`.
- R7: `overrun` stays set until reset, including across later good writes.
- R8: On each rising edge, `chainOut` takes `serBit` if `serValid`=1 and `localTake`=0. Otherwise it takes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 3 | Active-low select lines from the host |
| wrStrobe | input | 1 | Active-high write strobe from the host |
| dataIn | input | 8 | Configuration byte bus |
| localTake | input | 1 | High when the local path keeps the current bit |
| ready | output | 1 | High when another byte may be written |
| serValid | output | 1 | Serial bit valid |
| serBit | output | 1 | Serial bit, MSB first |
| chainOut | output | 1 | Daisy-chain serial output, idle high |
| overrun | output | 1 | Sticky flag for a write dropped while busy |

## Verification
The bench releases each of the four strobes in turn. It also changes the data bus in the same cycle as the release and shortly before it. A design that captured on the wrong edge, or that misaligned the data delay with the synchronizer, would emit a neighbouring or inverted byte. Partial strobe patterns check that a design decoding only some of the selects does not start a stream. A second write during a stream checks that a design which reloaded or queued the byte would show more than eight valid bits or a changed pattern. Random `localTake` patterns show whether kept bits leak onto the chain or forwarded bits arrive a cycle late.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef struct packed {
    logic load;   // take the aligned byte into the shifter
    logic shift;  // move one bit out this cycle
  } ldStrobe_t;
endpackage

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SEL_N       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_N-1:0] selN,
  input  logic             wrStrobe,
  output ldStrobe_t        strb,
  output logic             ready,
  output logic             serValid,
  output logic             overrun
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic                 writeReq;
  logic [SYNC_STAGES:0] reqPipe;
  logic                 releaseSeen;
  logic [CNT_W-1:0]     bitsLeft;
  logic                 active;

  assign writeReq = (&(~selN)) & wrStrobe;

  // stages 0..SYNC_STAGES-1 synchronize, the last stage holds the prior value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPipe <= '0;
    else       reqPipe <= {reqPipe[SYNC_STAGES-1:0], writeReq};
  end

  assign releaseSeen = reqPipe[SYNC_STAGES] & ~reqPipe[SYNC_STAGES-1];
  assign active      = (bitsLeft != '0);

  always_comb begin
    strb.load  = releaseSeen & ~active;
    strb.shift = active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bitsLeft <= '0;
    else if (strb.load) bitsLeft <= CNT_W'(DATA_W);
    else if (active)    bitsLeft <= bitsLeft - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      overrun <= 1'b0;
    else if (releaseSeen && active) overrun <= 1'b1;
  end

  assign ready    = ~active;
  assign serValid = active;
endmodule

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              localTake,
  input  ldStrobe_t         strb,
  output logic              serBit,
  output logic              chainOut
);
  localparam int PIPE_D = SYNC_STAGES + 1;

  logic [DATA_W-1:0] dataPipe [PIPE_D];
  logic [DATA_W-1:0] shReg;

  // delay line matched to the strobe synchronizer plus edge stage
  for (genvar g = 0; g < PIPE_D; g++) begin : gDelay
    if (g == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dataPipe[g] <= '0;
        else       dataPipe[g] <= dataIn;
      end
    end else begin : gTail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dataPipe[g] <= '0;
        else       dataPipe[g] <= dataPipe[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shReg <= '0;
    else if (strb.load)  shReg <= dataPipe[PIPE_D-1];
    else if (strb.shift) shReg <= {shReg[DATA_W-2:0], 1'b0};
  end

  assign serBit = shReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         chainOut <= 1'b1;
    else if (strb.shift && !localTake) chainOut <= serBit;
    else                               chainOut <= 1'b1;
  end
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SEL_N       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_N-1:0]  selN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              localTake,
  output logic              ready,
  output logic              serValid,
  output logic              serBit,
  output logic              chainOut,
  output logic              overrun
);
  ldStrobe_t strb;

  cfg_loader_ctrl #(
    .DATA_W(DATA_W), .SEL_N(SEL_N), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .wrStrobe(wrStrobe),
    .strb(strb), .ready(ready), .serValid(serValid), .overrun(overrun)
  );

  cfg_loader_dp #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .localTake(localTake),
    .strb(strb), .serBit(serBit), .chainOut(chainOut)
  );
endmodule

// File: rtl/cfg_byte_loader_chk.sv
module cfg_byte_loader_chk #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic localTake,
  input logic ready,
  input logic serValid,
  input logic serBit,
  input logic chainOut,
  input logic overrun
);
  localparam int RUN_W = $clog2(DATA_W + 2);
  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runCnt <= '0;
    else if (serValid) runCnt <= runCnt + 1'b1;
    else               runCnt <= '0;
  end

  // R4: a stream never exceeds one byte of bits
  a_r4_burst_len: assert property (@(posedge clk) disable iff (!rstN)
    serValid |-> (runCnt < RUN_W'(DATA_W)));

  // R3: leaving the ready state means bits are flowing
  a_r3_start: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> serValid);

  // R6: overrun only rises from a write seen while streaming
  a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(serValid));

  // R7: overrun is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R8: unkept bits forwarded one clock later
  a_r8_forward: assert property (@(posedge clk) disable iff (!rstN)
    (serValid && !localTake) |=> (chainOut == $past(serBit)));

  // R8: chain output idles high otherwise
  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(serValid && !localTake) |=> chainOut);
endmodule

bind cfg_byte_loader cfg_byte_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .localTake(localTake), .ready(ready),
  .serValid(serValid), .serBit(serBit), .chainOut(chainOut), .overrun(overrun)
);

// File: tb/cfg_byte_loader_bench.sv
module cfg_byte_loader_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] selN = 3'b111;
  logic       wrStrobe = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       localTake = 1'b0;
  logic       ready, serValid, serBit, chainOut, overrun;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cfg_byte_loader u_cfg_byte_loader (
    .clk(clk), .rstN(rstN), .selN(selN), .wrStrobe(wrStrobe),
    .dataIn(dataIn), .localTake(localTake), .ready(ready),
    .serValid(serValid), .serBit(serBit), .chainOut(chainOut),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expChain(input logic take, input logic bitv);
    return take ? 1'b1 : bitv;
  endfunction

  // assert all four; rel 0..2 releases that select, 3 releases the strobe
  task automatic doWrite(input logic [7:0] b, input int rel, input int hold);
    @(negedge clk);
    dataIn = ~b; selN = 3'b000; wrStrobe = 1'b1;
    for (int h = 1; h < hold; h++) begin
      @(negedge clk);
      if (h == hold - 1) dataIn = b;
    end
    if (hold == 1) dataIn = b;
    @(negedge clk);
    if (rel < 3) selN[rel] = 1'b1; else wrStrobe = 1'b0;
    dataIn = ~b;
  endtask

  task automatic streamCheck(input logic [7:0] b);
    logic ec = 1'b1;
    @(negedge clk);
    selN = 3'b111; wrStrobe = 1'b0;
    @(negedge clk);
    chk(serValid == 1'b0, "R3 early", int'(serValid), 0);
    chk(ready == 1'b1, "R3 ready before start", int'(ready), 1);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk(serValid == 1'b1, "R5 valid", int'(serValid), 1);
      chk(ready == 1'b0, "R4 busy", int'(ready), 0);
      chk(serBit == b[7-i], "R5 bit order", int'(serBit), int'(b[7-i]));
      chk(chainOut == ec, "R8 chain", int'(chainOut), int'(ec));
      localTake = 1'($urandom % 2);
      ec = expChain(localTake, b[7-i]);
      @(negedge clk);
    end
    chk(serValid == 1'b0, "R4 stream length", int'(serValid), 0);
    chk(ready == 1'b1, "R4 ready after", int'(ready), 1);
    chk(chainOut == ec, "R8 chain last", int'(chainOut), int'(ec));
  endtask

  task automatic partialWrite(input logic [2:0] s, input logic w);
    @(negedge clk);
    selN = s; wrStrobe = w; dataIn = 8'hC3;
    repeat (2) @(negedge clk);
    selN = 3'b111; wrStrobe = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(serValid == 1'b0 && ready == 1'b1, "R2 partial select",
          int'(serValid), 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int vcount;
    logic [7:0] got;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && serValid == 1'b0 && serBit == 1'b0, "R1 in reset", int'(ready), 1);
    chk(chainOut == 1'b1 && overrun == 1'b0, "R1 in reset", int'(chainOut), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && serValid == 1'b0, "R1 after reset", int'(serValid), 0);
    chk(chainOut == 1'b1 && overrun == 1'b0, "R1 after reset", int'(overrun), 0);

    // R2: partial strobe patterns
    partialWrite(3'b001, 1'b1);
    partialWrite(3'b100, 1'b1);
    partialWrite(3'b000, 1'b0);
    partialWrite(3'b010, 1'b0);

    // R3: release through each of the four strobes
    doWrite(8'h80, 0, 2); streamCheck(8'h80);
    doWrite(8'h01, 1, 1); streamCheck(8'h01);
    doWrite(8'hFF, 2, 3); streamCheck(8'hFF);
    doWrite(8'h00, 3, 2); streamCheck(8'h00);

    // random bytes, release pin and hold time
    for (int n = 0; n < 30; n++) begin
      logic [7:0] b = 8'($urandom);
      int rel = int'($urandom % 4);
      int hold = 1 + int'($urandom % 3);
      doWrite(b, rel, hold);
      streamCheck(b);
    end
    chk(overrun == 1'b0, "R6 no false overrun", int'(overrun), 0);

    // R6: second write during a stream
    doWrite(8'hA5, 3, 2);
    vcount = 0; got = '0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (k == 0) begin selN = 3'b111; wrStrobe = 1'b0; end
      if (k == 4) begin selN = 3'b000; wrStrobe = 1'b1; dataIn = 8'h3C; end
      if (k == 6) begin selN = 3'b111; wrStrobe = 1'b0; end
      if (serValid) begin vcount++; got = {got[6:0], serBit}; end
    end
    chk(vcount == 8, "R6 no extra bits", vcount, 8);
    chk(got == 8'hA5, "R6 stream unchanged", int'(got), 'hA5);
    chk(overrun == 1'b1, "R6 overrun set", int'(overrun), 1);

    // R7: sticky through a good write
    doWrite(8'h5A, 1, 2); streamCheck(8'h5A);
    chk(overrun == 1'b1, "R7 sticky", int'(overrun), 1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(overrun == 1'b0, "R7 cleared by reset", int'(overrun), 0);
    chk(ready == 1'b1 && chainOut == 1'b1, "R1 re-reset", int'(ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule